// File: doc/BRIEF.md
# Video Status Register Sprite Flags

This block holds the two status bytes that a host reads from a tile/sprite video processor. The first byte gathers three event flags (vertical interrupt, fifth sprite on a line, sprite collision) and a 5-bit sprite number. While no line has overflowed, that number follows the sprite evaluator as it walks the sprite table and ends each line at the highest sprite it handled. The first time an event shows five or more sprites on one line outside vertical blank, the overflow flag rises and the number is frozen on that sprite's index. It stays frozen until the host reads the first byte.

The second byte identifies the device. Its top three bits always read 1 and a three-bit device-type code follows them. The two lowest bits are a registered blanking indication and a horizontal interrupt flag, and a read of this byte clears that flag. A read clears only the flags that belong to the byte being read. The sprite number is never cleared by a read. If a flag is raised in the same cycle as a read that would clear it, the flag stays set.

The sprite evaluator drives one event per sprite handled: the index, whether the entry was a table terminator, and how many sprites have hit the line so far including this one. It also pulses a line-start strobe. The host side supplies a read strobe with a register select.

Top module: `vdp_status_regs`

## Requirements
- R1: After synchronous reset the first byte reads 0x00 and the second byte reads 1,1,1 followed by the device-type code in bits 4..2, with bits 1 and 0 at 0.
- R2: While the overflow flag is clear, every non-terminator sprite event copies its index into the sprite number (bits 4..0 of the first byte). A line-start strobe without an event returns the number to 0. A terminator event leaves the number unchanged, so a terminator on sprite 0 after line start leaves it at 0 and never raises the overflow flag.
- R3: A non-terminator event whose hit count is 5 or more, arriving while the overflow flag (bit 6) is clear and vertical blank is low, sets bit 6 and loads that event's index into the number. While bit 6 is set, later events and line starts do not change the number.
- R4: Bit 6 is never set while vertical blank is high.
- R5: The interrupt flag (bit 7) is set on the first cycle that vertical blank is seen high after being low.
- R6: A collision pulse sets the collision flag (bit 5).
- R7: A read with select 0 clears bits 7, 6 and 5 of the first byte one cycle later and leaves bits 4..0 unchanged.
- R8: A flag whose set condition occurs in the same cycle as a read that clears it stays set.
- R9: The second byte's bits 7..5 read 111 and bits 4..2 carry the device-type code at all times. Bit 1 shows the blanking input as it was in the previous cycle.
- R10: A horizontal-interrupt pulse sets bit 0 of the second byte, and a read with select 1 clears it. Reads with any other select change neither byte's flags.
- R11: When all 32 sprites are processed in order on a line without overflow, the number ends the line at 0x1F.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_valid | input | 1 | Sprite evaluation event this cycle |
| ev_term | input | 1 | The event's table entry is a terminator |
| ev_idx | input | 5 | Index of the sprite handled |
| ev_hits | input | 3 | Sprites on the current line, including this one |
| line_start | input | 1 | Start of a line's sprite evaluation |
| coll | input | 1 | Sprite collision pulse |
| vblank | input | 1 | Vertical blank level |
| blank | input | 1 | Combined blanking level |
| hint | input | 1 | Horizontal interrupt pulse |
| rd_stb | input | 1 | Host status read strobe |
| rd_sel | input | 4 | Status register select for the read |
| sr0 | output | 8 | First status byte: interrupt, overflow, collision, sprite number |
| sr1 | output | 8 | Second status byte: ident, type, blanking, horizontal interrupt |

## Verification
Every result of this block appears exactly one clock after the cycle that causes it: flags, the sprite number, the vertical-blank edge detection, the registered blanking bit and read clears all sit behind a single register. The bench changes the inputs just after a falling edge. It updates its own model of both bytes for the following rising edge and compares both outputs at the next falling edge, half a period clear of the edge that moved them. Directed sequences place set/clear collisions, the overflow latch, terminators and vertical-blank edges on known cycles, and seeded random stimulus covers the combinations between them.

// File: rtl/vstat_pkg.sv
package vstat_pkg;
  // flag slots held in the generic flag bank
  typedef enum int unsigned {
    FL_IRQ  = 0,
    FL_COLL = 1,
    FL_HINT = 2
  } flag_slot_e;

  localparam int unsigned NUM_FLAGS = 3;
  localparam int unsigned BYTE_W    = 8;
  localparam int unsigned IDENT_W   = 3;

  // layout of the first status byte
  typedef struct packed {
    logic       irq;
    logic       fifth;
    logic       coll;
    logic [4:0] num;
  } sr0_t;
endpackage

// File: rtl/vstat_flag_bank.sv
module vstat_flag_bank #(
  parameter int unsigned N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] q_o
);
  // set has priority over clear in every slot
  for (genvar g = 0; g < N; g++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)           q_o[g] <= 1'b0;
      else if (set_i[g]) q_o[g] <= 1'b1;
      else if (clr_i[g]) q_o[g] <= 1'b0;
    end
  end
endmodule

// File: rtl/vstat_sprite_track.sv
module vstat_sprite_track #(
  parameter int unsigned IDX_W    = 5,
  parameter int unsigned HIT_W    = 3,
  parameter int unsigned FIFTH_AT = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ev_valid,
  input  logic             ev_term,
  input  logic [IDX_W-1:0] ev_idx,
  input  logic [HIT_W-1:0] ev_hits,
  input  logic             line_start,
  input  logic             vblank,
  input  logic             clr,
  output logic             fifth_q,
  output logic [IDX_W-1:0] num_q
);
  localparam logic [HIT_W-1:0] LIMIT = HIT_W'(FIFTH_AT);

  logic real_ev;
  logic set_fifth;

  assign real_ev   = ev_valid & ~ev_term;
  assign set_fifth = real_ev & (ev_hits >= LIMIT) & ~fifth_q & ~vblank;

  always_ff @(posedge clk) begin
    if (rst) begin
      fifth_q <= 1'b0;
      num_q   <= '0;
    end else begin
      if (set_fifth)  fifth_q <= 1'b1;
      else if (clr)   fifth_q <= 1'b0;
      // number tracks only while no overflow is latched
      if (!fifth_q) begin
        if (real_ev)         num_q <= ev_idx;
        else if (line_start) num_q <= '0;
      end
    end
  end
endmodule

// File: rtl/vstat_ident.sv
module vstat_ident #(
  parameter int unsigned DEV_TYPE = 1,
  parameter int unsigned TYPE_W   = 3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       blank,
  input  logic       hflag,
  output logic [7:0] sr1
);
  localparam logic [TYPE_W-1:0] TYPE_CODE = TYPE_W'(DEV_TYPE);

  logic blank_q;

  always_ff @(posedge clk) begin
    if (rst) blank_q <= 1'b0;
    else     blank_q <= blank;
  end

  assign sr1 = {3'b111, TYPE_CODE, blank_q, hflag};
endmodule

// File: rtl/vdp_status_regs.sv
module vdp_status_regs
  import vstat_pkg::*;
#(
  parameter int unsigned NUM_SPR  = 32,
  parameter int unsigned HIT_W    = 3,
  parameter int unsigned FIFTH_AT = 5,
  parameter int unsigned SEL_W    = 4,
  parameter int unsigned SEL_SR0  = 0,
  parameter int unsigned SEL_SR1  = 1,
  parameter int unsigned DEV_TYPE = 1
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       ev_valid,
  input  logic                       ev_term,
  input  logic [$clog2(NUM_SPR)-1:0] ev_idx,
  input  logic [HIT_W-1:0]           ev_hits,
  input  logic                       line_start,
  input  logic                       coll,
  input  logic                       vblank,
  input  logic                       blank,
  input  logic                       hint,
  input  logic                       rd_stb,
  input  logic [SEL_W-1:0]           rd_sel,
  output logic [BYTE_W-1:0]          sr0,
  output logic [BYTE_W-1:0]          sr1
);
  localparam int unsigned IDX_W = $clog2(NUM_SPR);

  logic                 vb_q;
  logic                 rd0, rd1;
  logic [NUM_FLAGS-1:0] fl_set, fl_clr, fl_q;
  logic                 fifth_q;
  logic [IDX_W-1:0]     num_q;
  sr0_t                 sr0_s;

  assign rd0 = rd_stb & (rd_sel == SEL_W'(SEL_SR0));
  assign rd1 = rd_stb & (rd_sel == SEL_W'(SEL_SR1));

  always_ff @(posedge clk) begin
    if (rst) vb_q <= 1'b0;
    else     vb_q <= vblank;
  end

  always_comb begin
    fl_set          = '0;
    fl_clr          = '0;
    fl_set[FL_IRQ]  = vblank & ~vb_q;
    fl_clr[FL_IRQ]  = rd0;
    fl_set[FL_COLL] = coll;
    fl_clr[FL_COLL] = rd0;
    fl_set[FL_HINT] = hint;
    fl_clr[FL_HINT] = rd1;
  end

  vstat_flag_bank #(.N(NUM_FLAGS)) u_flags (
    .clk   (clk),
    .rst   (rst),
    .set_i (fl_set),
    .clr_i (fl_clr),
    .q_o   (fl_q)
  );

  vstat_sprite_track #(
    .IDX_W    (IDX_W),
    .HIT_W    (HIT_W),
    .FIFTH_AT (FIFTH_AT)
  ) u_track (
    .clk        (clk),
    .rst        (rst),
    .ev_valid   (ev_valid),
    .ev_term    (ev_term),
    .ev_idx     (ev_idx),
    .ev_hits    (ev_hits),
    .line_start (line_start),
    .vblank     (vblank),
    .clr        (rd0),
    .fifth_q    (fifth_q),
    .num_q      (num_q)
  );

  vstat_ident #(
    .DEV_TYPE (DEV_TYPE),
    .TYPE_W   (IDENT_W)
  ) u_ident (
    .clk   (clk),
    .rst   (rst),
    .blank (blank),
    .hflag (fl_q[FL_HINT]),
    .sr1   (sr1)
  );

  always_comb begin
    sr0_s.irq   = fl_q[FL_IRQ];
    sr0_s.fifth = fifth_q;
    sr0_s.coll  = fl_q[FL_COLL];
    sr0_s.num   = 5'(num_q);
  end
  assign sr0 = sr0_s;
endmodule

// File: rtl/vstat_checker.sv
module vstat_checker #(
  parameter int unsigned SEL_W    = 4,
  parameter int unsigned DEV_TYPE = 1
) (
  input logic             clk,
  input logic             rst,
  input logic             ev_valid,
  input logic             line_start,
  input logic             coll,
  input logic             vblank,
  input logic             hint,
  input logic             rd_stb,
  input logic [SEL_W-1:0] rd_sel,
  input logic [7:0]       sr0,
  input logic [7:0]       sr1
);
  logic rd_first, rd_second;
  assign rd_first  = rd_stb && rd_sel == SEL_W'(0);
  assign rd_second = rd_stb && rd_sel == SEL_W'(1);

  // R7: read of the first byte clears the collision flag when no collision arrives
  a_r7_read_clears: assert property (@(posedge clk) disable iff (rst)
    rd_first && !coll |=> !sr0[5]);
  // R7: read keeps the sprite number when nothing else moves it
  a_r7_num_kept: assert property (@(posedge clk) disable iff (rst)
    rd_first && !ev_valid && !line_start |=> sr0[4:0] == $past(sr0[4:0]));
  // R3: number frozen while overflow is latched
  a_r3_num_frozen: assert property (@(posedge clk) disable iff (rst)
    sr0[6] |=> $stable(sr0[4:0]));
  // R4: no overflow raised in vertical blank
  a_r4_no_fifth_vblank: assert property (@(posedge clk) disable iff (rst)
    vblank && !sr0[6] |=> !sr0[6]);
  // R5: vertical blank edge raises the interrupt flag
  a_r5_irq_on_rise: assert property (@(posedge clk) disable iff (rst)
    $rose(vblank) |=> sr0[7]);
  // R6, R8: collision sets its flag even against a clearing read
  a_r8_coll_wins: assert property (@(posedge clk) disable iff (rst)
    coll |=> sr0[5]);
  // R10: horizontal interrupt sets its flag even against a clearing read
  a_r10_hint_set: assert property (@(posedge clk) disable iff (rst)
    hint |=> sr1[0]);
  // R10: second byte read without a new pulse clears the flag
  a_r10_hint_clear: assert property (@(posedge clk) disable iff (rst)
    rd_second && !hint |=> !sr1[0]);
  // R9: ident field
  a_r9_ident: assert property (@(posedge clk) disable iff (rst)
    sr1[7:2] == {3'b111, 3'(DEV_TYPE)});
endmodule

bind vdp_status_regs vstat_checker #(.SEL_W(SEL_W), .DEV_TYPE(DEV_TYPE)) u_vstat_chk (
  .clk        (clk),
  .rst        (rst),
  .ev_valid   (ev_valid),
  .line_start (line_start),
  .coll       (coll),
  .vblank     (vblank),
  .hint       (hint),
  .rd_stb     (rd_stb),
  .rd_sel     (rd_sel),
  .sr0        (sr0),
  .sr1        (sr1)
);

// File: tb/vdp_status_regs_test.sv
`timescale 1ns/100ps
module vdp_status_regs_test;
  localparam int unsigned DEV_T = 1;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ev_valid = 0, ev_term = 0, line_start = 0, coll = 0;
  logic       vblank = 0, blank = 0, hint = 0, rd_stb = 0;
  logic [4:0] ev_idx = 0;
  logic [2:0] ev_hits = 0;
  logic [3:0] rd_sel = 0;
  logic [7:0] sr0, sr1;

  int n_chk = 0;
  int n_bad = 0;

  // bench model of the two bytes
  logic m_irq, m_fifth, m_coll, m_h, m_blank, m_vbq;
  logic [4:0] m_num;

  always #2.5 clk = ~clk;

  vdp_status_regs #(.DEV_TYPE(DEV_T)) uut (
    .clk(clk), .rst(rst), .ev_valid(ev_valid), .ev_term(ev_term),
    .ev_idx(ev_idx), .ev_hits(ev_hits), .line_start(line_start),
    .coll(coll), .vblank(vblank), .blank(blank), .hint(hint),
    .rd_stb(rd_stb), .rd_sel(rd_sel), .sr0(sr0), .sr1(sr1)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] exp_sr1();
    return {3'b111, 3'(DEV_T), m_blank, m_h};
  endfunction

  task automatic model_reset();
    m_irq = 0; m_fifth = 0; m_coll = 0; m_h = 0; m_blank = 0; m_vbq = 0; m_num = 0;
  endtask

  task automatic model_step();
    logic r0, r1, s5;
    r0 = rd_stb && rd_sel == 4'd0;
    r1 = rd_stb && rd_sel == 4'd1;
    s5 = ev_valid && !ev_term && ev_hits >= 3'd5 && !m_fifth && !vblank;
    if (!m_fifth) begin
      if (ev_valid && !ev_term) m_num = ev_idx;
      else if (line_start)      m_num = 5'd0;
    end
    m_irq   = (vblank && !m_vbq) || (m_irq && !r0);
    m_fifth = s5 || (m_fifth && !r0);
    m_coll  = coll || (m_coll && !r0);
    m_h     = hint || (m_h && !r1);
    m_blank = blank;
    m_vbq   = vblank;
  endtask

  task automatic compare_all();
    check("R5 irq flag",      sr0[7],    m_irq);
    check("R3/R4 fifth flag", sr0[6],    m_fifth);
    check("R6 coll flag",     sr0[5],    m_coll);
    check("R2 sprite number", sr0[4:0],  m_num);
    check("R9 ident byte",    sr1[7:1],  exp_sr1() >> 1);
    check("R10 hint flag",    sr1[0],    m_h);
  endtask

  // inputs already set after a falling edge; advance one cycle and compare
  task automatic cyc();
    model_step();
    @(negedge clk);
    compare_all();
  endtask

  task automatic idle();
    ev_valid = 0; ev_term = 0; line_start = 0; coll = 0; hint = 0; rd_stb = 0;
  endtask

  task automatic ev(input logic [4:0] i, input logic [2:0] h, input logic t);
    idle(); ev_valid = 1; ev_idx = i; ev_hits = h; ev_term = t; cyc();
  endtask

  task automatic rd(input logic [3:0] s);
    idle(); rd_stb = 1; rd_sel = s; cyc();
  endtask

  initial begin
    #100000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst = 0;
    // R1: reset values
    check("R1 sr0 after reset", sr0, 8'h00);
    check("R1 sr1 after reset", sr1, {3'b111, 3'(DEV_T), 2'b00});

    // R11: walk all 32 sprites, no overflow
    idle(); line_start = 1; cyc();
    for (int i = 0; i < 32; i++) ev(5'(i), 3'd1, 1'b0);
    check("R11 number after full walk", sr0[4:0], 8'h1F);

    // R2: terminator on sprite 0 after line start
    idle(); line_start = 1; cyc();
    ev(5'd0, 3'd5, 1'b1);
    check("R2 terminator keeps number 0", sr0[4:0], 0);
    check("R2 terminator raises no overflow", sr0[6], 0);

    // R3: fifth sprite latch at index 7
    idle(); line_start = 1; cyc();
    ev(5'd2, 3'd1, 0); ev(5'd3, 3'd2, 0); ev(5'd4, 3'd3, 0);
    ev(5'd6, 3'd4, 0); ev(5'd7, 3'd5, 0);
    check("R3 overflow set", sr0[6], 1);
    check("R3 number latched", sr0[4:0], 7);
    ev(5'd9, 3'd6, 0);
    idle(); line_start = 1; cyc();
    check("R3 number frozen", sr0[4:0], 7);

    // R10: reads with other selects leave flags alone
    rd(4'd2);
    check("R10 other select keeps overflow", sr0[6], 1);

    // R7: read clears flags, number stays
    idle(); coll = 1; cyc();
    rd(4'd0);
    check("R7 flags cleared", sr0[7:5], 0);
    check("R7 number kept", sr0[4:0], 7);

    // R8: collision and clearing read together
    idle(); coll = 1; rd_stb = 1; rd_sel = 0; cyc();
    check("R8 coll survives read", sr0[5], 1);
    // R8: overflow and clearing read together
    idle(); ev_valid = 1; ev_idx = 5'd12; ev_hits = 3'd5; rd_stb = 1; rd_sel = 0; cyc();
    check("R8 fifth survives read", sr0[6], 1);
    check("R8 number at new index", sr0[4:0], 12);
    rd(4'd0);

    // R4 and R5: vertical blank
    idle(); vblank = 1; cyc();
    check("R5 irq on vblank rise", sr0[7], 1);
    ev(5'd20, 3'd7, 0);
    check("R4 no overflow in vblank", sr0[6], 0);
    rd(4'd0);
    cyc();
    check("R5 no retrigger while high", sr0[7], 0);
    idle(); vblank = 0; cyc();

    // R9, R10: second byte
    idle(); blank = 1; hint = 1; cyc();
    check("R9 blank bit", sr1[1], 1);
    check("R10 hint set", sr1[0], 1);
    rd(4'd1);
    check("R10 hint cleared by read", sr1[0], 0);
    idle(); blank = 0; cyc();

    // seeded random mix
    void'($urandom(32'd1234));
    for (int k = 0; k < 3000; k++) begin
      idle();
      if ($urandom_range(1, 0) == 1) begin
        ev_valid = 1;
        ev_idx   = 5'($urandom_range(31, 0));
        ev_hits  = 3'($urandom_range(7, 0));
        ev_term  = ($urandom_range(9, 0) == 0);
      end else begin
        line_start = ($urandom_range(3, 0) == 0);
      end
      coll   = ($urandom_range(9, 0) == 0);
      hint   = ($urandom_range(9, 0) == 0);
      rd_stb = ($urandom_range(3, 0) == 0);
      rd_sel = 4'($urandom_range(3, 0));
      blank  = ($urandom_range(1, 0) == 1);
      if ($urandom_range(19, 0) == 0) vblank = ~vblank;
      cyc();
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule